// File: doc/BRIEF.md
# Burst Write Master Adapter

This block turns simple internal write commands into AXI4 write traffic on the AW, W and B channels. A command carries a start byte address and a burst length in beats. The data words for all bursts arrive on a separate stream, in command order. Commands wait in a request queue. Data words wait in a data buffer sized to hold a full burst for every write that may be in flight. A credit counter caps the number of writes that have been issued but not yet answered with a B response.

A queued command moves onto AW when the address slot is free and a credit is available. Each accepted address is remembered in a small length queue. The W side starts a burst only after its address has been accepted and only once the whole burst is present in the data buffer. From then on the beats go out back to back, with WLAST on the final one. Every B response is passed back as a one-cycle completion pulse. A response other than OKAY sets a sticky error flag.

Top module: `wburst_master`

## Requirements
- R1: While reset is applied and in the first cycles after it, awvalid, wvalid, done_valid and err_flag are low. Once reset has been released, cmd_ready, wd_ready and bready are high.
- R2: Each AW transfer carries the command's address on awaddr and its beat count minus one on awlen. awburst is INCR (2'b01) and awsize is log2 of the bytes per word (2 for 32-bit data). Addresses appear in the order the commands were accepted.
- R3: Once awvalid is high without awready, awvalid, awaddr and awlen hold steady until the handshake.
- R4: The W beats carry the accepted data words in order. wstrb is all ones. wlast is high on exactly the last beat, and each burst has cmd_len beats.
- R5: No beat of a burst appears on W before that burst's address has been accepted on AW.
- R6: A burst starts on W only when all of its words are buffered. From then on wvalid stays high until the beat with wlast is accepted.
- R7: The number of AW transfers accepted minus the number of B responses never exceeds MAX_OUTSTANDING (4). A command held back by this limit is issued after a B response arrives.
- R8: Each B handshake produces exactly one done_valid pulse in the following cycle, with done_resp equal to the bresp value.
- R9: A B response whose bresp is not OKAY (2'b00) sets err_flag in the following cycle. err_flag then stays set until reset.
- R10: cmd_ready falls once the request queue (MAX_OUTSTANDING entries) and the address slot are full. wd_ready falls once the data buffer holds MAX_OUTSTANDING × MAX_BURST words (32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_addr | input | ADDR_W | Burst start byte address |
| cmd_len | input | LEN_W | Beats in the burst, 1 to MAX_BURST |
| wd_valid | input | 1 | Data word offered |
| wd_ready | output | 1 | Data word accepted when high with wd_valid |
| wd_data | input | DATA_W | Data word |
| done_valid | output | 1 | One-cycle pulse per completed write |
| done_resp | output | 2 | Response code of the completed write |
| err_flag | output | 1 | Sticky error indication |
| awvalid | output | 1 | AXI write address valid |
| awready | input | 1 | AXI write address ready |
| awaddr | output | ADDR_W | AXI write address |
| awlen | output | 8 | AXI burst length minus one |
| awsize | output | 3 | AXI beat size code |
| awburst | output | 2 | AXI burst type |
| wvalid | output | 1 | AXI write data valid |
| wready | input | 1 | AXI write data ready |
| wdata | output | DATA_W | AXI write data |
| wstrb | output | DATA_W/8 | AXI byte strobes |
| wlast | output | 1 | AXI last beat of burst |
| bvalid | input | 1 | AXI write response valid |
| bready | output | 1 | AXI write response ready |
| bresp | input | 2 | AXI write response code |

## Verification
A directed case sends a full-length command while only part of its data has arrived. No beat may appear until the rest is supplied, and the beats must then run without gaps; this tells buffered issue apart from beat-by-beat forwarding. A second case holds back all B responses, so the fifth command must wait until exactly one response is released; this exposes an off-by-one in the credit limit. A third case stalls the slave completely to fill both queues, and the accepted counts show their depths. Randomised traffic with mixed lengths and random ready patterns then checks address fields, data order and wlast placement. A final error response separates a sticky flag from one that merely follows bresp.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;

  typedef enum logic {WS_IDLE, WS_BURST} wseq_state_t;

  function automatic logic [2:0] size_code(input int bytes);
    return 3'($clog2(bytes));
  endfunction

endpackage

// File: rtl/wbm_rst_sync.sv
module wbm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/wbm_fifo.sv
module wbm_fifo #(
  parameter  int WIDTH = 8,
  parameter  int DEPTH = 4,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [PW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             full, empty, do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_ptr_d = do_push ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = do_pop  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_d;
      if (do_pop)  rd_ptr_q <= rd_ptr_d;
      if (do_push || do_pop) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= din;
  end

  assign dout  = mem[rd_ptr_q];
  assign count = cnt_q;

endmodule

// File: rtl/wbm_credit.sv
module wbm_credit #(
  parameter  int MAX_OUT = 4,
  localparam int OCW     = $clog2(MAX_OUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic avail
);

  logic [OCW-1:0] cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    cnt_en = take ^ give;
    cnt_d  = cnt_q + OCW'(take) - OCW'(give);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign avail = (cnt_q < OCW'(MAX_OUT));

endmodule

// File: rtl/wbm_wseq.sv
module wbm_wseq
  import wbm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4,
  parameter int DCW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_avail,
  input  logic [LEN_W-1:0]  len_head,
  output logic              len_pop,
  input  logic [DCW-1:0]    data_count,
  input  logic [DATA_W-1:0] data_head,
  output logic              data_pop,
  output logic              wvalid,
  input  logic              wready,
  output logic [DATA_W-1:0] wdata,
  output logic              wlast
);

  localparam int CMPW = (DCW > LEN_W) ? DCW : LEN_W;

  wseq_state_t      state_q, state_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic             start, beat, state_en;

  assign start = (state_q == WS_IDLE) && len_avail &&
                 (CMPW'(data_count) >= CMPW'(len_head));
  assign beat  = (state_q == WS_BURST) && wready;

  always_comb begin
    state_d  = state_q;
    left_d   = left_q;
    state_en = start || beat;
    if (start) begin
      state_d = WS_BURST;
      left_d  = len_head;
    end else if (beat) begin
      left_d = left_q - LEN_W'(1);
      if (left_q == LEN_W'(1)) state_d = WS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      left_q  <= '0;
    end else if (state_en) begin
      state_q <= state_d;
      left_q  <= left_d;
    end
  end

  assign len_pop  = start;
  assign data_pop = beat;
  assign wvalid   = (state_q == WS_BURST);
  assign wdata    = data_head;
  assign wlast    = (state_q == WS_BURST) && (left_q == LEN_W'(1));

endmodule

// File: rtl/wburst_master.sv
module wburst_master
  import wbm_pkg::*;
#(
  parameter  int ADDR_W          = 32,
  parameter  int DATA_W          = 32,
  parameter  int MAX_BURST       = 8,
  parameter  int MAX_OUTSTANDING = 4,
  localparam int LEN_W           = $clog2(MAX_BURST + 1),
  localparam int STRB_W          = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [DATA_W-1:0] wd_data,
  output logic              done_valid,
  output logic [1:0]        done_resp,
  output logic              err_flag,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [7:0]        awlen,
  output logic [2:0]        awsize,
  output logic [1:0]        awburst,
  output logic              wvalid,
  input  logic              wready,
  output logic [DATA_W-1:0] wdata,
  output logic [STRB_W-1:0] wstrb,
  output logic              wlast,
  input  logic              bvalid,
  output logic              bready,
  input  logic [1:0]        bresp
);

  localparam int DBUF_DEPTH = MAX_OUTSTANDING * MAX_BURST;
  localparam int DCW        = $clog2(DBUF_DEPTH + 1);
  localparam int RCW        = $clog2(MAX_OUTSTANDING + 1);
  localparam int REQ_W      = ADDR_W + LEN_W;
  localparam logic [2:0] AW_SIZE = size_code(STRB_W);

  logic              rst_n_i;
  logic [REQ_W-1:0]  req_head;
  logic [RCW-1:0]    req_count;
  logic              req_avail, aw_load, credit_ok, aw_hs;
  logic [LEN_W-1:0]  len_head;
  logic [RCW-1:0]    len_count;
  logic              len_pop;
  logic [DATA_W-1:0] data_head;
  logic [DCW-1:0]    data_count;
  logic              data_pop;

  logic              aw_valid_q, aw_valid_d;
  logic [ADDR_W-1:0] aw_addr_q;
  logic [LEN_W-1:0]  aw_len_q;
  logic [LEN_W-1:0]  aw_len_m1;

  logic              done_q;
  logic [1:0]        resp_q;
  logic              err_q, err_d;

  wbm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  // request queue: {address, length}
  wbm_fifo #(.WIDTH(REQ_W), .DEPTH(MAX_OUTSTANDING)) u_req_q (
    .clk   (clk),
    .rst_n (rst_n_i),
    .push  (cmd_valid),
    .din   ({cmd_addr, cmd_len}),
    .pop   (aw_load),
    .dout  (req_head),
    .count (req_count)
  );

  assign cmd_ready = rst_n_i && (req_count != RCW'(MAX_OUTSTANDING));
  assign req_avail = (req_count != '0);

  wbm_credit #(.MAX_OUT(MAX_OUTSTANDING)) u_credit (
    .clk   (clk),
    .rst_n (rst_n_i),
    .take  (aw_load),
    .give  (bvalid),
    .avail (credit_ok)
  );

  // address slot
  assign aw_hs   = aw_valid_q && awready;
  assign aw_load = req_avail && credit_ok && (!aw_valid_q || awready);

  always_comb begin
    aw_valid_d = aw_valid_q;
    if (aw_load)    aw_valid_d = 1'b1;
    else if (aw_hs) aw_valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      aw_valid_q <= 1'b0;
      aw_addr_q  <= '0;
      aw_len_q   <= '0;
    end else begin
      if (aw_load || aw_hs) aw_valid_q <= aw_valid_d;
      if (aw_load) begin
        aw_addr_q <= req_head[REQ_W-1:LEN_W];
        aw_len_q  <= req_head[LEN_W-1:0];
      end
    end
  end

  assign aw_len_m1 = aw_len_q - LEN_W'(1);
  assign awvalid   = aw_valid_q;
  assign awaddr    = aw_addr_q;
  assign awlen     = 8'(aw_len_m1);
  assign awsize    = AW_SIZE;
  assign awburst   = BURST_INCR;

  // lengths of bursts whose address is accepted, in AW order
  wbm_fifo #(.WIDTH(LEN_W), .DEPTH(MAX_OUTSTANDING)) u_len_q (
    .clk   (clk),
    .rst_n (rst_n_i),
    .push  (aw_hs),
    .din   (aw_len_q),
    .pop   (len_pop),
    .dout  (len_head),
    .count (len_count)
  );

  wbm_fifo #(.WIDTH(DATA_W), .DEPTH(DBUF_DEPTH)) u_data_q (
    .clk   (clk),
    .rst_n (rst_n_i),
    .push  (wd_valid),
    .din   (wd_data),
    .pop   (data_pop),
    .dout  (data_head),
    .count (data_count)
  );

  assign wd_ready = rst_n_i && (data_count != DCW'(DBUF_DEPTH));

  wbm_wseq #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DCW(DCW)) u_wseq (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .len_avail  (len_count != '0),
    .len_head   (len_head),
    .len_pop    (len_pop),
    .data_count (data_count),
    .data_head  (data_head),
    .data_pop   (data_pop),
    .wvalid     (wvalid),
    .wready     (wready),
    .wdata      (wdata),
    .wlast      (wlast)
  );

  assign wstrb = '1;

  // response side
  assign bready = rst_n_i;
  assign err_d  = err_q || (bresp != RESP_OKAY);

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      done_q <= 1'b0;
      resp_q <= RESP_OKAY;
      err_q  <= 1'b0;
    end else begin
      done_q <= bvalid;
      if (bvalid) begin
        resp_q <= bresp;
        err_q  <= err_d;
      end
    end
  end

  assign done_valid = done_q;
  assign done_resp  = resp_q;
  assign err_flag   = err_q;

endmodule

// File: rtl/wburst_master_chk.sv
module wburst_master_chk #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int MAX_OUT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              awvalid,
  input logic              awready,
  input logic [ADDR_W-1:0] awaddr,
  input logic [7:0]        awlen,
  input logic              wvalid,
  input logic              wready,
  input logic [DATA_W-1:0] wdata,
  input logic              wlast,
  input logic              bvalid,
  input logic [1:0]        bresp,
  input logic              done_valid,
  input logic [1:0]        done_resp,
  input logic              err_flag
);

  logic [7:0] open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= '0;
    else        open_q <= open_q + 8'(awvalid && awready) - 8'(bvalid);
  end

  a_r3_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));

  a_r4_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));

  a_r6_w_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !(wready && wlast) |=> wvalid);

  a_r7_open_limit: assert property (@(posedge clk) disable iff (!rst_n)
    open_q <= 8'(MAX_OUT));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |=> done_valid && (done_resp == $past(bresp)));

  a_r8_no_extra_done: assert property (@(posedge clk) disable iff (!rst_n)
    !bvalid |=> !done_valid);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

endmodule

bind wburst_master wburst_master_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_OUT(MAX_OUTSTANDING)
) u_chk (.*);

// File: tb/wburst_master_test.sv
module wburst_master_test;

  localparam int CLK_P   = 10;
  localparam int MAXB    = 8;
  localparam int MAXO    = 4;
  localparam int DBUF    = MAXO * MAXB;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready;
  logic [31:0] cmd_addr;
  logic [3:0]  cmd_len;
  logic        wd_valid, wd_ready;
  logic [31:0] wd_data;
  logic        done_valid;
  logic [1:0]  done_resp;
  logic        err_flag;
  logic        awvalid, awready;
  logic [31:0] awaddr;
  logic [7:0]  awlen;
  logic [2:0]  awsize;
  logic [1:0]  awburst;
  logic        wvalid, wready;
  logic [31:0] wdata;
  logic [3:0]  wstrb;
  logic        wlast;
  logic        bvalid, bready;
  logic [1:0]  bresp;

  wburst_master uut (.*);

  always #(CLK_P/2) clk = ~clk;

  int errors = 0;
  int checks = 0;

  // stimulus sources
  logic [31:0] src_addr[$];
  int          src_len[$];
  logic [31:0] src_data[$];
  // expectations
  logic [31:0] exp_addr[$];
  int          exp_len[$];
  logic [31:0] exp_data[$];
  int          burst_len[$];
  int          beat_idx = 0;
  int          b_pending = 0;
  int          open_cnt = 0;
  // slave behaviour
  int          p_cmd = 100, p_dat = 100, p_aw = 100, p_w = 100, p_b = 100;
  int          b_budget = 1000000;
  bit          err_next = 0;
  // tallies
  int          aw_seen = 0, w_seen = 0, cmd_acc = 0, dat_acc = 0;
  int          b_sent = 0, done_cnt = 0;
  bit          exp_done = 0;
  logic [1:0]  exp_resp = 2'b00;
  bit          exp_err = 0;
  logic [31:0] next_addr = 32'h0000_1000;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit roll(input int pct);
    return ($urandom_range(99, 0) < pct);
  endfunction

  task automatic add_cmd(input int len, input int ndata);
    src_addr.push_back(next_addr);
    src_len.push_back(len);
    next_addr = next_addr + 32'(len * 4) + 32'h40;
    for (int i = 0; i < ndata; i++) src_data.push_back($urandom());
  endtask

  // one cycle, called at a falling edge
  task automatic step();
    // R8, R9: outputs registered from the previous cycle's response
    if (exp_done || done_valid) begin
      chk(done_valid == exp_done, "R8", "done_valid", done_valid, exp_done);
      if (exp_done)
        chk(done_resp == exp_resp, "R8", "done_resp", done_resp, exp_resp);
    end
    if (done_valid) done_cnt++;
    chk(err_flag == exp_err, "R9", "err_flag", err_flag, exp_err);

    // command source
    cmd_valid = (src_len.size() > 0) && roll(p_cmd);
    cmd_addr  = (src_len.size() > 0) ? src_addr[0] : 32'h0;
    cmd_len   = (src_len.size() > 0) ? 4'(src_len[0]) : 4'h0;
    if (cmd_valid && cmd_ready) begin
      exp_addr.push_back(src_addr.pop_front());
      exp_len.push_back(src_len.pop_front());
      cmd_acc++;
    end

    // data source
    wd_valid = (src_data.size() > 0) && roll(p_dat);
    wd_data  = (src_data.size() > 0) ? src_data[0] : 32'h0;
    if (wd_valid && wd_ready) begin
      exp_data.push_back(src_data.pop_front());
      dat_acc++;
    end

    // AW slave
    awready = roll(p_aw);
    if (awvalid && awready) begin
      aw_seen++;
      if (exp_len.size() == 0) begin
        chk(0, "R2", "unexpected AW", 1, 0);
      end else begin
        chk(awaddr == exp_addr[0], "R2", "awaddr", awaddr, exp_addr[0]);
        chk(awlen == 8'(exp_len[0] - 1), "R2", "awlen", awlen, exp_len[0] - 1);
        chk(awburst == 2'b01, "R2", "awburst", awburst, 1);
        chk(awsize == 3'd2, "R2", "awsize", awsize, 2);
        burst_len.push_back(exp_len[0]);
        void'(exp_addr.pop_front());
        void'(exp_len.pop_front());
      end
      open_cnt++;
      chk(open_cnt <= MAXO, "R7", "open writes", open_cnt, MAXO);
    end

    // B slave (before W so a response never shares the last beat's cycle)
    bvalid = 1'b0;
    bresp  = 2'b00;
    if (b_pending > 0 && b_budget > 0 && roll(p_b)) begin
      bvalid = 1'b1;
      bresp  = err_next ? 2'b10 : 2'b00;
      err_next = 0;
    end
    exp_done = bvalid && bready;
    exp_resp = bresp;
    if (bvalid && bready) begin
      b_pending--;
      b_budget--;
      open_cnt--;
      b_sent++;
      if (bresp != 2'b00) exp_err = 1;
    end

    // W slave
    if (beat_idx > 0)
      chk(wvalid == 1'b1, "R6", "wvalid gap inside burst", wvalid, 1);
    wready = roll(p_w);
    if (wvalid && wready) begin
      w_seen++;
      if (burst_len.size() == 0) begin
        chk(0, "R5", "W beat before its AW", 1, 0);
      end else begin
        chk(exp_data.size() > 0 && wdata == exp_data[0], "R4", "wdata",
            wdata, exp_data.size() > 0 ? exp_data[0] : 0);
        chk(wstrb == 4'hF, "R4", "wstrb", wstrb, 15);
        chk(wlast == (beat_idx == burst_len[0] - 1), "R4", "wlast",
            wlast, beat_idx == burst_len[0] - 1);
        if (exp_data.size() > 0) void'(exp_data.pop_front());
        if (beat_idx == burst_len[0] - 1) begin
          beat_idx = 0;
          void'(burst_len.pop_front());
          b_pending++;
        end else begin
          beat_idx++;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drain();
    int guard = 0;
    while ((src_len.size() + src_data.size() + exp_len.size() +
            burst_len.size() + b_pending) > 0 && guard < 20000) begin
      step();
      guard++;
    end
    run(4);
    chk(guard < 20000, "R7", "drain completes", guard, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int a0, c0, d0;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    cmd_valid = 0; cmd_addr = 0; cmd_len = 0;
    wd_valid = 0; wd_data = 0;
    awready = 0; wready = 0; bvalid = 0; bresp = 0;
    repeat (3) @(negedge clk);
    chk(awvalid == 0 && wvalid == 0, "R1", "valids in reset", {awvalid, wvalid}, 0);
    chk(done_valid == 0 && err_flag == 0, "R1", "done/err in reset",
        {done_valid, err_flag}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_ready && wd_ready && bready, "R1", "readies after reset",
        {cmd_ready, wd_ready, bready}, 7);
    chk(awvalid == 0 && wvalid == 0 && done_valid == 0, "R1",
        "outputs idle after reset", {awvalid, wvalid, done_valid}, 0);

    // R6: an 8-beat burst with only 5 words buffered must not start
    add_cmd(8, 5);
    w_seen = 0;
    run(30);
    chk(w_seen == 0 && wvalid == 0, "R6", "partial burst held", w_seen, 0);
    chk(aw_seen == 1, "R5", "address issued ahead of data", aw_seen, 1);
    for (int i = 0; i < 3; i++) src_data.push_back($urandom());
    drain();
    chk(w_seen == 8, "R4", "beats in burst", w_seen, 8);

    // R7: hold responses, only MAXO addresses may go out
    b_budget = 0;
    a0 = aw_seen;
    for (int i = 0; i < 6; i++) add_cmd(2, 2);
    run(60);
    chk(aw_seen - a0 == MAXO, "R7", "AW issued while B held", aw_seen - a0, MAXO);
    b_budget = 1;
    run(20);
    chk(aw_seen - a0 == MAXO + 1, "R7", "AW after one B", aw_seen - a0, MAXO + 1);
    b_budget = 1000000;
    drain();

    // R10: stall the slave and fill both queues
    p_aw = 0; p_w = 0;
    c0 = cmd_acc; d0 = dat_acc;
    for (int i = 0; i < 8; i++) add_cmd(5, 5);
    run(60);
    chk(cmd_acc - c0 == MAXO + 1, "R10", "commands accepted", cmd_acc - c0, MAXO + 1);
    chk(cmd_ready == 0, "R10", "cmd_ready when full", cmd_ready, 0);
    chk(dat_acc - d0 == DBUF, "R10", "words accepted", dat_acc - d0, DBUF);
    chk(wd_ready == 0, "R10", "wd_ready when full", wd_ready, 0);
    p_aw = 100; p_w = 100;
    drain();

    // random traffic, all responses OKAY
    p_cmd = 70; p_dat = 60; p_aw = 55; p_w = 65; p_b = 40;
    for (int i = 0; i < 60; i++) add_cmd($urandom_range(MAXB, 1), 0);
    begin
      int total = 0;
      foreach (src_len[k]) total += src_len[k];
      for (int i = 0; i < total; i++) src_data.push_back($urandom());
    end
    drain();
    chk(err_flag == 0, "R9", "no error after OKAY traffic", err_flag, 0);

    // R9: one error response, then OKAY, flag stays
    p_cmd = 100; p_dat = 100; p_aw = 100; p_w = 100; p_b = 100;
    err_next = 1;
    add_cmd(3, 3);
    drain();
    chk(err_flag == 1, "R9", "flag after error", err_flag, 1);
    add_cmd(1, 1);
    drain();
    chk(err_flag == 1, "R9", "flag sticky after OKAY", err_flag, 1);
    chk(done_cnt == b_sent, "R8", "done pulses vs responses", done_cnt, b_sent);
    chk(aw_seen == b_sent, "R2", "every address answered", aw_seen, b_sent);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule